// File: doc/BRIEF.md
# Exception and Status Controller

This block is the privileged control unit of a small 32-bit in-order processor. It owns three control registers: a status word, a cause word and an exception return address. It takes synchronous exception requests, each with a 5-bit code, and one level-sensitive interrupt line. It steers the fetch stage to the exception vector, and it performs the return-from-exception sequence.

It also decodes the move-to and move-from instructions aimed at the control register space. Through them, software can read the status, cause and return address, and can overwrite the status word.

Each cycle the pipeline presents the instruction being retired, with its address and a flag that says whether it sits in a branch delay slot. An accepted event, or a return, produces a one-cycle redirect pulse on the cycle after acceptance, together with the new fetch address. Move-from results appear combinationally in the same cycle, as a write-back request to the general register file.

Top module: `exc_ctrl`

## Requirements
- R1: After reset the status word reads 0x00400002: boot-vector bit 22 set, exception-level bit 1 set, interrupt-enable bit 0 clear. Cause and return address read 0, and no redirect is issued.
- R2: An interrupt is accepted only while status bit 0 is set. It records exception code 0, and no redirect occurs because of it while bit 0 is clear.
- R3: An interrupt seen while masked stays pending after the line drops. It is accepted in the first cycle that status bit 0 reads as set.
- R4: An event accepted while status bit 1 is clear writes the code into cause bits 6:2 and clears the other cause bits. Cause bit 31 takes the delay-slot flag, and the return address becomes the instruction address, or that address minus 4 when the flag is set. Status bit 1 is then set.
- R5: An event accepted while status bit 1 is already set leaves the cause and the return address unchanged.
- R6: Every accepted event pulses the redirect for exactly the following cycle. The target is 0xBFC00380 when status bit 22 is set and 0x80000180 otherwise.
- R7: A return instruction is recognised when bits 31:26 = 0x10, bits 25:21 = 0x10 and bits 5:0 = 0x18. It redirects to the stored return address and clears status bit 1.
- R8: A move-from is recognised when bits 31:26 = 0x10, bits 25:21 = 0x00 and bits 10:0 are zero. It asserts the write-back strobe with register index bits 20:16. It returns the status, the cause or the return address for control register 12, 13 or 14 (bits 15:11).
- R9: A move-to (bits 25:21 = 0x04, bits 10:0 zero) naming control register 12 replaces the status word from the next cycle on. A move-to naming any other control register, and an encoding with nonzero bits 10:0, changes nothing.
- R10: A move-from naming any control register other than 12, 13 or 14 returns 0xDEADC0DE.
- R11: An exception request wins over a pending interrupt in the same cycle, and the interrupt stays pending. Any accepted event suppresses the same-cycle return, move-to and move-from write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| instr_valid_i | input | 1 | Instruction word below is retiring this cycle |
| instr_i | input | 32 | Retiring instruction word |
| instr_pc_i | input | 32 | Address of the retiring instruction |
| delay_slot_i | input | 1 | Retiring instruction sits in a branch delay slot |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 5 | Code of the requested exception |
| irq_i | input | 1 | Interrupt request line |
| gpr_wdata_i | input | 32 | General register value for a move-to |
| redirect_o | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc_o | output | 32 | Fetch target while the redirect is high |
| rd_we_o | output | 1 | Move-from write-back strobe |
| rd_gpr_o | output | 5 | General register index for the write-back |
| rd_data_o | output | 32 | Control register value for the write-back |

## Verification
Directed sequences walk the ordering cases. One is a masked interrupt that is later unmasked by a status write, which separates a held request from a dropped one. Others are a first versus a nested exception, which separates recording from preserving the return address, and delay-slot versus plain faults, which exposes the minus-4 adjustment and bit 31. Boot-vector on versus off exposes the base selection, and colliding exception, interrupt and return in one cycle exposes the priority. Seeded random streams then mix well-formed and malformed control instructions with random requests and status values, against a bench reference model.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN = 32;
    localparam int CODE_W = 5;
    localparam int IDX_W = 5;

    // status bit positions
    localparam int ST_IE  = 0;
    localparam int ST_EXL = 1;
    localparam int ST_BEV = 22;
    // cause bit positions
    localparam int CA_BD   = 31;
    localparam int CA_CODE = 2;

    // instruction fields
    localparam logic [5:0] OP_CTRL = 6'h10;
    localparam logic [4:0] RS_FROM = 5'h00;
    localparam logic [4:0] RS_TO   = 5'h04;
    localparam logic [4:0] RS_CO   = 5'h10;
    localparam logic [5:0] FN_RET  = 6'h18;

    localparam logic [IDX_W-1:0] REG_STATUS = 5'd12;
    localparam logic [IDX_W-1:0] REG_CAUSE  = 5'd13;
    localparam logic [IDX_W-1:0] REG_EPC    = 5'd14;

    typedef struct packed {
        logic [XLEN-1:0] status;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] epc;
        logic            pend;
        logic            redir;
        logic [XLEN-1:0] redir_pc;
    } ctl_state_t;
endpackage

// File: rtl/exc_decode.sv
module exc_decode
    import exc_pkg::*;
(
    input  logic            valid_i,
    input  logic [XLEN-1:0] instr_i,
    output logic            is_from_o,
    output logic            is_to_o,
    output logic            is_ret_o,
    output logic [IDX_W-1:0] gpr_idx_o,
    output logic [IDX_W-1:0] ctl_idx_o
);
    logic       ctrl_op;
    logic [4:0] rs_f;
    logic       low_zero;

    always_comb begin
        ctrl_op   = valid_i && (instr_i[31:26] == OP_CTRL);
        rs_f      = instr_i[25:21];
        low_zero  = (instr_i[10:0] == 11'd0);
        is_from_o = ctrl_op && (rs_f == RS_FROM) && low_zero;
        is_to_o   = ctrl_op && (rs_f == RS_TO) && low_zero;
        is_ret_o  = ctrl_op && (rs_f == RS_CO) && (instr_i[5:0] == FN_RET);
        gpr_idx_o = instr_i[20:16];
        ctl_idx_o = instr_i[15:11];
    end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] BOOT_BASE = 32'hBFC0_0200,
    parameter logic [XLEN-1:0] RUN_BASE  = 32'h8000_0000,
    parameter logic [XLEN-1:0] VEC_OFF   = 32'h0000_0180
) (
    input  logic            bev_i,
    output logic [XLEN-1:0] target_o
);
    localparam logic [XLEN-1:0] BOOT_VEC = BOOT_BASE + VEC_OFF;
    localparam logic [XLEN-1:0] RUN_VEC  = RUN_BASE + VEC_OFF;

    always_comb begin
        target_o = bev_i ? BOOT_VEC : RUN_VEC;
    end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] DEBUG_WORD = 32'hDEAD_C0DE,
    parameter logic [XLEN-1:0] BOOT_BASE  = 32'hBFC0_0200,
    parameter logic [XLEN-1:0] RUN_BASE   = 32'h8000_0000,
    parameter logic [XLEN-1:0] VEC_OFF    = 32'h0000_0180
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              instr_valid_i,
    input  logic [31:0]       instr_i,
    input  logic [31:0]       instr_pc_i,
    input  logic              delay_slot_i,
    input  logic              exc_req_i,
    input  logic [4:0]        exc_code_i,
    input  logic              irq_i,
    input  logic [31:0]       gpr_wdata_i,
    output logic              redirect_o,
    output logic [31:0]       redirect_pc_o,
    output logic              rd_we_o,
    output logic [4:0]        rd_gpr_o,
    output logic [31:0]       rd_data_o
);
    localparam logic [XLEN-1:0] RESET_STATUS =
        (XLEN'(1) << ST_BEV) | (XLEN'(1) << ST_EXL);
    localparam logic [XLEN-1:0] SLOT_BYTES = XLEN'(4);

    ctl_state_t st_d, st_q;

    logic             is_from, is_to, is_ret;
    logic [IDX_W-1:0] gpr_idx, ctl_idx;
    logic [XLEN-1:0]  vec_target;
    logic             pend_eff, take_exc, take_irq, take_any;
    logic [CODE_W-1:0] take_code;

    exc_decode u_decode (
        .valid_i   (instr_valid_i),
        .instr_i   (instr_i),
        .is_from_o (is_from),
        .is_to_o   (is_to),
        .is_ret_o  (is_ret),
        .gpr_idx_o (gpr_idx),
        .ctl_idx_o (ctl_idx)
    );

    exc_vector #(
        .BOOT_BASE (BOOT_BASE),
        .RUN_BASE  (RUN_BASE),
        .VEC_OFF   (VEC_OFF)
    ) u_vector (
        .bev_i    (st_q.status[ST_BEV]),
        .target_o (vec_target)
    );

    // next-state computation
    always_comb begin
        st_d       = st_q;
        st_d.redir = 1'b0;
        pend_eff   = st_q.pend | irq_i;
        take_exc   = exc_req_i;
        take_irq   = !exc_req_i && pend_eff && st_q.status[ST_IE];
        take_any   = take_exc || take_irq;
        take_code  = take_exc ? exc_code_i : '0;

        if (take_any) begin
            if (!st_q.status[ST_EXL]) begin
                st_d.cause = '0;
                st_d.cause[CA_CODE +: CODE_W] = take_code;
                st_d.cause[CA_BD] = delay_slot_i;
                st_d.epc = delay_slot_i ? (instr_pc_i - SLOT_BYTES) : instr_pc_i;
            end
            st_d.status[ST_EXL] = 1'b1;
            st_d.redir          = 1'b1;
            st_d.redir_pc       = vec_target;
        end else if (is_ret) begin
            st_d.status[ST_EXL] = 1'b0;
            st_d.redir          = 1'b1;
            st_d.redir_pc       = st_q.epc;
        end else if (is_to && (ctl_idx == REG_STATUS)) begin
            st_d.status = gpr_wdata_i;
        end

        st_d.pend = take_irq ? 1'b0 : pend_eff;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.status   <= RESET_STATUS;
            st_q.cause    <= '0;
            st_q.epc      <= '0;
            st_q.pend     <= 1'b0;
            st_q.redir    <= 1'b0;
            st_q.redir_pc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // move-from read path
    always_comb begin
        rd_we_o  = is_from && !take_any;
        rd_gpr_o = gpr_idx;
        case (ctl_idx)
            REG_STATUS: rd_data_o = st_q.status;
            REG_CAUSE:  rd_data_o = st_q.cause;
            REG_EPC:    rd_data_o = st_q.epc;
            default:    rd_data_o = DEBUG_WORD;
        endcase
    end

    assign redirect_o    = st_q.redir;
    assign redirect_pc_o = st_q.redir_pc;

    // checks on the control state
    assert_masked_no_redirect_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.status[ST_IE] && !exc_req_i && !is_ret) |=> !redirect_o);

    assert_pending_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.pend && !st_q.status[ST_IE]) |=> st_q.pend);

    assert_first_records_epc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_req_i && !st_q.status[ST_EXL]) |=>
        (st_q.status[ST_EXL] &&
         st_q.epc == ($past(delay_slot_i) ? $past(instr_pc_i) - SLOT_BYTES : $past(instr_pc_i))));

    assert_nested_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_req_i && st_q.status[ST_EXL]) |=> ($stable(st_q.epc) && $stable(st_q.cause)));

    assert_vector_target_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_req_i |=> (redirect_o &&
        redirect_pc_o == ($past(st_q.status[ST_BEV]) ? BOOT_BASE + VEC_OFF : RUN_BASE + VEC_OFF)));

    assert_return_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_ret && !take_any) |=>
        (redirect_o && redirect_pc_o == $past(st_q.epc) && !st_q.status[ST_EXL]));

    assert_event_over_return_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_req_i && is_ret) |=> st_q.status[ST_EXL]);
endmodule

// File: tb/exc_ctrl_tb_top.sv
`timescale 1ns/1ps
module exc_ctrl_tb_top;
    localparam int MAX_CYCLES = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        v = 1'b0;
    logic [31:0] ins = '0, pc = '0, wd = '0;
    logic        ds = 1'b0, ex = 1'b0, irq = 1'b0;
    logic [4:0]  code = '0;
    logic        redirect_o, rd_we_o;
    logic [31:0] redirect_pc_o, rd_data_o;
    logic [4:0]  rd_gpr_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model
    logic [31:0] m_st, m_ca, m_epc;
    logic        m_pend;
    logic [31:0] last_rd;

    always #2 clk = ~clk;

    exc_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(v), .instr_i(ins),
        .instr_pc_i(pc), .delay_slot_i(ds), .exc_req_i(ex), .exc_code_i(code),
        .irq_i(irq), .gpr_wdata_i(wd), .redirect_o(redirect_o),
        .redirect_pc_o(redirect_pc_o), .rd_we_o(rd_we_o), .rd_gpr_o(rd_gpr_o),
        .rd_data_o(rd_data_o)
    );

    function automatic logic [31:0] enc_from(input logic [4:0] rt, input logic [4:0] rd);
        return {6'h10, 5'h00, rt, rd, 11'h0};
    endfunction
    function automatic logic [31:0] enc_to(input logic [4:0] rt, input logic [4:0] rd);
        return {6'h10, 5'h04, rt, rd, 11'h0};
    endfunction
    function automatic logic [31:0] enc_ret();
        return {6'h10, 5'h10, 15'h0, 6'h18};
    endfunction
    function automatic logic [31:0] model_read(input logic [4:0] rd);
        case (rd)
            5'd12: return m_st;
            5'd13: return m_ca;
            5'd14: return m_epc;
            default: return 32'hDEAD_C0DE;
        endcase
    endfunction
    function automatic logic [31:0] model_vec();
        return m_st[22] ? 32'hBFC0_0380 : 32'h8000_0180;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 32'h0040_0002; m_ca = '0; m_epc = '0; m_pend = 1'b0;
    endtask

    // one retirement cycle, checked against the model
    task automatic cyc(input logic iv, input logic [31:0] iw, input logic [31:0] ipc,
                       input logic ids, input logic iex, input logic [4:0] icode,
                       input logic iirq, input logic [31:0] iwd);
        logic ctrl, is_from, is_to, is_ret, pend_eff, t_exc, t_irq, take, e_redir;
        logic [31:0] e_pc;
        @(negedge clk);
        v = iv; ins = iw; pc = ipc; ds = ids; ex = iex; code = icode; irq = iirq; wd = iwd;
        #1;
        ctrl    = iv && iw[31:26] == 6'h10;
        is_from = ctrl && iw[25:21] == 5'h00 && iw[10:0] == 0;
        is_to   = ctrl && iw[25:21] == 5'h04 && iw[10:0] == 0;
        is_ret  = ctrl && iw[25:21] == 5'h10 && iw[5:0] == 6'h18;
        pend_eff = m_pend | iirq;
        t_exc   = iex;
        t_irq   = !iex && pend_eff && m_st[0];
        take    = t_exc || t_irq;
        last_rd = rd_data_o;
        chk("R11 write-back strobe", 32'(rd_we_o), 32'(is_from && !take));
        if (is_from && !take) begin
            chk("R8 register index", 32'(rd_gpr_o), 32'(iw[20:16]));
            chk((iw[15:11] inside {5'd12, 5'd13, 5'd14}) ? "R8 read data" : "R10 read data",
                rd_data_o, model_read(iw[15:11]));
        end
        e_redir = 1'b0; e_pc = '0;
        if (take) begin
            if (!m_st[1]) begin
                m_ca = {ids, 24'd0, (t_exc ? icode : 5'd0), 2'b00};
                m_epc = ids ? ipc - 32'd4 : ipc;
            end
            e_redir = 1'b1; e_pc = model_vec();
            m_st[1] = 1'b1;
        end else if (is_ret) begin
            e_redir = 1'b1; e_pc = m_epc; m_st[1] = 1'b0;
        end else if (is_to && iw[15:11] == 5'd12) begin
            m_st = iwd;
        end
        m_pend = t_irq ? 1'b0 : pend_eff;
        @(posedge clk); #1;
        chk(take ? "R6 redirect pulse" : (is_ret ? "R7 redirect" : "R2 no redirect"),
            32'(redirect_o), 32'(e_redir));
        if (e_redir)
            chk(take ? "R6 vector target" : "R7 return target", redirect_pc_o, e_pc);
    endtask

    task automatic idle(input logic iirq);
        cyc(1'b0, 32'h0, 32'h0000_4000, 1'b0, 1'b0, 5'd0, iirq, 32'h0);
    endtask
    task automatic read_chk(input logic [4:0] rd, input logic [31:0] exp, input string req);
        cyc(1'b1, enc_from(5'd7, rd), 32'h0, 1'b0, 1'b0, 5'd0, 1'b0, 32'h0);
        chk(req, last_rd, exp);
    endtask

    initial begin
        #(MAX_CYCLES * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'h0005_EED1);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 reset redirect", 32'(redirect_o), 32'd0);
        read_chk(5'd12, 32'h0040_0002, "R1 reset status");
        read_chk(5'd13, 32'h0, "R1 reset cause");
        read_chk(5'd14, 32'h0, "R1 reset epc");
        read_chk(5'd5, 32'hDEAD_C0DE, "R10 unimplemented read");

        // writes that must not take effect
        cyc(1'b1, enc_to(5'd2, 5'd5), 32'h0, 1'b0, 1'b0, 5'd0, 1'b0, 32'hFFFF_FFFF);
        cyc(1'b1, enc_to(5'd2, 5'd12) | 32'h1, 32'h0, 1'b0, 1'b0, 5'd0, 1'b0, 32'h0);
        read_chk(5'd12, 32'h0040_0002, "R9 ignored writes");

        // masked interrupt then unmask
        idle(1'b1);
        chk("R2 masked irq no redirect", 32'(redirect_o), 32'd0);
        idle(1'b0);
        chk("R3 still masked", 32'(redirect_o), 32'd0);
        cyc(1'b1, enc_to(5'd3, 5'd12), 32'h0, 1'b0, 1'b0, 5'd0, 1'b0, 32'h0000_0001);
        chk("R9 status write timing", 32'(redirect_o), 32'd0);
        idle(1'b0);
        chk("R3 pending taken", 32'(redirect_o), 32'd1);
        chk("R6 run vector", redirect_pc_o, 32'h8000_0180);
        read_chk(5'd13, 32'h0, "R2 interrupt code");
        read_chk(5'd14, 32'h0000_4000, "R4 epc of interrupt");

        // return
        cyc(1'b1, enc_ret(), 32'h0, 1'b0, 1'b0, 5'd0, 1'b0, 32'h0);
        chk("R7 return target", redirect_pc_o, 32'h0000_4000);
        read_chk(5'd12, 32'h0000_0001, "R7 exl cleared");

        // first exception in delay slot, then nested
        cyc(1'b1, 32'h0, 32'h0000_1000, 1'b1, 1'b1, 5'd5, 1'b0, 32'h0);
        read_chk(5'd13, 32'h8000_0014, "R4 cause with bd");
        read_chk(5'd14, 32'h0000_0FFC, "R4 epc minus four");
        cyc(1'b1, 32'h0, 32'h0000_2000, 1'b0, 1'b1, 5'd9, 1'b0, 32'h0);
        chk("R5 nested redirect", 32'(redirect_o), 32'd1);
        read_chk(5'd13, 32'h8000_0014, "R5 cause kept");
        read_chk(5'd14, 32'h0000_0FFC, "R5 epc kept");

        // boot vector
        cyc(1'b1, enc_to(5'd3, 5'd12), 32'h0, 1'b0, 1'b0, 5'd0, 1'b0, 32'h0040_0000);
        cyc(1'b1, 32'h0, 32'h0000_3000, 1'b0, 1'b1, 5'd3, 1'b0, 32'h0);
        chk("R6 boot vector", redirect_pc_o, 32'hBFC0_0380);
        read_chk(5'd13, 32'h0000_000C, "R4 cause plain");

        // priority cases
        cyc(1'b1, enc_to(5'd3, 5'd12), 32'h0, 1'b0, 1'b0, 5'd0, 1'b0, 32'h0000_0001);
        cyc(1'b1, enc_ret(), 32'h0000_5000, 1'b0, 1'b1, 5'd7, 1'b1, 32'h0);
        chk("R11 event beats return", redirect_pc_o, 32'h8000_0180);
        idle(1'b0);
        chk("R11 irq kept pending", 32'(redirect_o), 32'd1);
        cyc(1'b1, enc_from(5'd4, 5'd12), 32'h0, 1'b0, 1'b1, 5'd1, 1'b0, 32'h0);
        read_chk(5'd12, 32'h0000_0003, "R11 status after events");

        // seeded random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w, d;
            int sel;
            sel = int'($urandom % 8);
            d = $urandom;
            case (sel)
                0: w = enc_ret();
                1, 2: w = enc_from(5'($urandom), ($urandom % 2) ? 5'(12 + $urandom % 3) : 5'($urandom));
                3: begin w = enc_to(5'($urandom), 5'd12); d = {d[31:23], 1'($urandom % 2), d[21:2], 2'b01}; end
                4: w = enc_to(5'($urandom), 5'($urandom));
                5: w = enc_from(5'($urandom), 5'd12) | 32'(1 + $urandom % 2047);
                6: w = $urandom;
                default: w = 32'h0;
            endcase
            cyc(($urandom % 8) != 0, w, $urandom & 32'hFFFF_FFFC, ($urandom % 3) == 0,
                ($urandom % 6) == 0, 5'($urandom), ($urandom % 5) == 0, d);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule